// File: doc/BRIEF.md
# Neighbourhood Coherence Hazard Scoreboard

This block guards the entry of a pipelined event predictor in a discrete-event particle simulator. The simulated volume is cut into a cubic grid of cells. Each cell has a small occupancy counter. The counter records how many events from that cell are still travelling through the predictor. Before an event is allowed in, the block looks at the 27 cells around the event's own cell: the cell itself plus every cell one step away along any combination of axes. If any of those cells is occupied, the event would read stale particle state, so the block raises a stall.

An event that enters without a stall marks its cell. When that event commits, the retire port releases the cell again. Neighbour coordinates wrap at the faces of the grid, as they do in a periodic simulation box. A clear pulse empties the whole map at once. It is used when a causality restart throws away every event in flight.

The grid edge is a power of two and is set by a parameter. A full-size 32-cell edge is allowed, and the default of an 8-cell edge keeps simulation small. The counter width is derived from the predictor depth.

Top module: `nhs_scoreboard`

## Requirements
- R1: After reset every cell is empty, so an enter request to any cell sees `stall` low.
- R2: An enter request seen with `stall` low (and `clear` low) marks its cell occupied from the next clock edge. A later enter request to the same cell then stalls.
- R3: `stall` is high in the same cycle as an enter request exactly when at least one of the 27 cells is occupied. Those cells are the ones whose x, y and z each differ from the request by -1, 0 or +1. A cell two steps away on any axis does not cause a stall.
- R4: Neighbour coordinates wrap modulo the grid edge. With an edge of 8, coordinate 7 is adjacent to 0, while 6 and 0 are two steps apart.
- R5: An enter request seen with `stall` high is not recorded and leaves the map unchanged.
- R6: `stall` stays high for a repeated request until a retire releases every conflicting cell. A retire decrements the counter of its cell, and the cell is free when the counter reaches zero.
- R7: When a retire and an enter arrive in the same cycle, the retire is applied first. An enter whose only conflict is the cell being retired in that cycle is therefore accepted.
- R8: A retire to a cell whose counter is zero is ignored. The counter does not wrap below zero.
- R9: A cycle with `clear` high empties every cell from the next edge. An enter request in that cycle is not recorded.
- R10: `stall` is low whenever `enter_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Empty the whole map (restart) |
| enter_valid | input | 1 | An event asks to enter the predictor |
| enter_x | input | GRID_BITS | Cell x of the entering event |
| enter_y | input | GRID_BITS | Cell y of the entering event |
| enter_z | input | GRID_BITS | Cell z of the entering event |
| retire_valid | input | 1 | An event leaves the predictor |
| retire_x | input | GRID_BITS | Cell x of the retiring event |
| retire_y | input | GRID_BITS | Cell y of the retiring event |
| retire_z | input | GRID_BITS | Cell z of the retiring event |
| stall | output | 1 | Entry refused this cycle: neighbourhood occupied |

## Verification
Four properties are checked on every cycle:
- `stall` never rises without an enter request.
- `stall` stays low after a clear.
- `stall` stays low while nothing has been admitted since the last reset or clear.
- An event just admitted blocks an immediate second request to the same cell.

Some behaviours are only visible across longer sequences of stimulus, so the directed scenarios cover them:
- the exact extent of the 27-cell window, including distance-two misses;
- wrap-around at the grid faces;
- retire-before-enter ordering in a shared cycle;
- the no-underflow rule for empty cells;
- the fact that a stalled request leaves nothing behind.

// File: rtl/nhs_pkg.sv
package nhs_pkg;
   // neighbourhood is a cube of side NBR_SPAN centred on the event cell
   localparam int NBR_SPAN  = 3;
   localparam int NBR_COUNT = NBR_SPAN * NBR_SPAN * NBR_SPAN;
   // largest supported grid edge is 2**MAX_GRID_BITS cells
   localparam int MAX_GRID_BITS = 5;

   typedef enum logic [1:0] {
      STEP_DOWN = 2'd0,
      STEP_HOLD = 2'd1,
      STEP_UP   = 2'd2
   } axis_step_e;
endpackage

// File: rtl/nhs_nbr_gen.sv
// Produces the flat indices {z,y,x} of the 27 cells around a centre cell,
// wrapping each axis modulo the grid edge.
module nhs_nbr_gen
   import nhs_pkg::*;
#(
   parameter int GRID_BITS = 3,
   localparam int IDX_W = 3 * GRID_BITS
) (
   input  logic [GRID_BITS-1:0]             ctr_x,
   input  logic [GRID_BITS-1:0]             ctr_y,
   input  logic [GRID_BITS-1:0]             ctr_z,
   output logic [NBR_COUNT-1:0][IDX_W-1:0]  nbr_idx
);
   for (genvar dz = 0; dz < NBR_SPAN; dz++) begin : g_z
      for (genvar dy = 0; dy < NBR_SPAN; dy++) begin : g_y
         for (genvar dx = 0; dx < NBR_SPAN; dx++) begin : g_x
            localparam int K = (dz * NBR_SPAN + dy) * NBR_SPAN + dx;
            logic [GRID_BITS-1:0] nx, ny, nz;
            // power-of-two edge: modular wrap falls out of the adder width
            always_comb begin
               nx = ctr_x + GRID_BITS'(dx) - GRID_BITS'(STEP_HOLD);
               ny = ctr_y + GRID_BITS'(dy) - GRID_BITS'(STEP_HOLD);
               nz = ctr_z + GRID_BITS'(dz) - GRID_BITS'(STEP_HOLD);
            end
            assign nbr_idx[K] = {nz, ny, nx};
         end
      end
   end
endmodule

// File: rtl/nhs_cell_array.sv
// One saturating occupancy counter per cell. Reports, per cell, whether the
// cell is still occupied once this cycle's retire has been taken into account.
module nhs_cell_array #(
   parameter int GRID_BITS = 3,
   parameter int DEPTH     = 23,
   localparam int IDX_W = 3 * GRID_BITS,
   localparam int CELLS = 1 << IDX_W,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wipe,
   input  logic             inc_en,
   input  logic [IDX_W-1:0] inc_idx,
   input  logic             dec_en,
   input  logic [IDX_W-1:0] dec_idx,
   output logic [CELLS-1:0] busy_after_dec
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   for (genvar c = 0; c < CELLS; c++) begin : g_cell
      localparam logic [IDX_W-1:0] SELF = IDX_W'(c);
      logic [CNT_W-1:0] cnt_q;
      logic             hit_inc, hit_dec;

      always_comb begin
         hit_inc = inc_en && (inc_idx == SELF) && (cnt_q != CNT_MAX);
         hit_dec = dec_en && (dec_idx == SELF) && (cnt_q != '0);
      end

      always_ff @(posedge clk) begin
         if (!rst_n || wipe) begin
            cnt_q <= '0;
         end else if (hit_inc && !hit_dec) begin
            cnt_q <= cnt_q + CNT_ONE;
         end else if (hit_dec && !hit_inc) begin
            cnt_q <= cnt_q - CNT_ONE;
         end
      end

      // retire applies first: a lone event being retired this cycle frees the cell
      assign busy_after_dec[c] = (cnt_q > CNT_ONE) || ((cnt_q == CNT_ONE) && !hit_dec);
   end
endmodule

// File: rtl/nhs_hazard_or.sv
// Looks up each neighbour in the occupancy vector and ORs the results.
module nhs_hazard_or
   import nhs_pkg::*;
#(
   parameter int GRID_BITS = 3,
   localparam int IDX_W = 3 * GRID_BITS,
   localparam int CELLS = 1 << IDX_W
) (
   input  logic [CELLS-1:0]                 busy,
   input  logic [NBR_COUNT-1:0][IDX_W-1:0]  nbr_idx,
   output logic                             any_hit
);
   logic [NBR_COUNT-1:0] hit_vec;

   for (genvar k = 0; k < NBR_COUNT; k++) begin : g_look
      assign hit_vec[k] = busy[nbr_idx[k]];
   end

   assign any_hit = |hit_vec;
endmodule

// File: rtl/nhs_scoreboard.sv
module nhs_scoreboard
   import nhs_pkg::*;
#(
   parameter int GRID_BITS = 3,
   parameter int DEPTH     = 23
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 enter_valid,
   input  logic [GRID_BITS-1:0] enter_x,
   input  logic [GRID_BITS-1:0] enter_y,
   input  logic [GRID_BITS-1:0] enter_z,
   input  logic                 retire_valid,
   input  logic [GRID_BITS-1:0] retire_x,
   input  logic [GRID_BITS-1:0] retire_y,
   input  logic [GRID_BITS-1:0] retire_z,
   output logic                 stall
);
   localparam int IDX_W = 3 * GRID_BITS;
   localparam int CELLS = 1 << IDX_W;

   if (GRID_BITS < 1 || GRID_BITS > MAX_GRID_BITS) begin : g_bad_grid
      $error("nhs_scoreboard: GRID_BITS out of range");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("nhs_scoreboard: DEPTH must be positive");
   end

   logic [NBR_COUNT-1:0][IDX_W-1:0] nbr_idx;
   logic [CELLS-1:0]                busy;
   logic                            hazard;
   logic                            admit, release_en;

   nhs_nbr_gen #(.GRID_BITS(GRID_BITS)) u_nbr (
      .ctr_x   (enter_x),
      .ctr_y   (enter_y),
      .ctr_z   (enter_z),
      .nbr_idx (nbr_idx)
   );

   nhs_hazard_or #(.GRID_BITS(GRID_BITS)) u_haz (
      .busy    (busy),
      .nbr_idx (nbr_idx),
      .any_hit (hazard)
   );

   assign stall      = enter_valid && hazard;
   assign admit      = enter_valid && !hazard && !clear;
   assign release_en = retire_valid && !clear;

   nhs_cell_array #(.GRID_BITS(GRID_BITS), .DEPTH(DEPTH)) u_cells (
      .clk            (clk),
      .rst_n          (rst_n),
      .wipe           (clear),
      .inc_en         (admit),
      .inc_idx        ({enter_z, enter_y, enter_x}),
      .dec_en         (release_en),
      .dec_idx        ({retire_z, retire_y, retire_x}),
      .busy_after_dec (busy)
   );
endmodule

// File: rtl/nhs_scoreboard_checker.sv
module nhs_scoreboard_checker #(
   parameter int GRID_BITS = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 clear,
   input logic                 enter_valid,
   input logic [GRID_BITS-1:0] enter_x,
   input logic [GRID_BITS-1:0] enter_y,
   input logic [GRID_BITS-1:0] enter_z,
   input logic                 retire_valid,
   input logic                 stall
);
   // set once anything has been admitted since the last reset or clear
   logic any_live;
   always_ff @(posedge clk) begin
      if (!rst_n || clear) any_live <= 1'b0;
      else if (enter_valid && !stall) any_live <= 1'b1;
   end

   // R10
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enter_valid |-> !stall);

   // R9
   p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !stall);

   // R1
   p_fresh_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !any_live |-> !stall);

   // R2
   p_self_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_valid && !stall && !clear) |=>
         (!(enter_valid && !retire_valid &&
            enter_x == $past(enter_x) && enter_y == $past(enter_y) &&
            enter_z == $past(enter_z)) || stall));
endmodule

bind nhs_scoreboard nhs_scoreboard_checker #(.GRID_BITS(GRID_BITS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .clear        (clear),
   .enter_valid  (enter_valid),
   .enter_x      (enter_x),
   .enter_y      (enter_y),
   .enter_z      (enter_z),
   .retire_valid (retire_valid),
   .stall        (stall)
);

// File: tb/nhs_scoreboard_test.sv
module nhs_scoreboard_test;
   localparam int GB = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear = 1'b0;
   logic          enter_valid = 1'b0;
   logic [GB-1:0] enter_x = '0, enter_y = '0, enter_z = '0;
   logic          retire_valid = 1'b0;
   logic [GB-1:0] retire_x = '0, retire_y = '0, retire_z = '0;
   logic          stall;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk; // 125 MHz

   nhs_scoreboard #(.GRID_BITS(GB), .DEPTH(23)) uut (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .enter_valid(enter_valid), .enter_x(enter_x), .enter_y(enter_y), .enter_z(enter_z),
      .retire_valid(retire_valid), .retire_x(retire_x), .retire_y(retire_y), .retire_z(retire_z),
      .stall(stall)
   );

   // one cycle: drive at negedge, look at stall before the next rising edge
   task automatic step(input logic ev, input int ex, input int ey, input int ez,
                       input logic rv, input int rx, input int ry, input int rz,
                       input logic cl, input logic exp_stall, input string req);
      @(negedge clk);
      enter_valid  = ev;
      enter_x = GB'(ex); enter_y = GB'(ey); enter_z = GB'(ez);
      retire_valid = rv;
      retire_x = GB'(rx); retire_y = GB'(ry); retire_z = GB'(rz);
      clear = cl;
      #1;
      checks++;
      if (stall !== exp_stall) begin
         fails++;
         $display("FAIL %s: stall=%b expected %b (enter %0d,%0d,%0d)",
                  req, stall, exp_stall, ex, ey, ez);
      end
   endtask

   task automatic enter(input int x, input int y, input int z,
                        input logic exp_stall, input string req);
      step(1'b1, x, y, z, 1'b0, 0, 0, 0, 1'b0, exp_stall, req);
   endtask

   task automatic retire(input int x, input int y, input int z, input string req);
      step(1'b0, 0, 0, 0, 1'b1, x, y, z, 1'b0, 1'b0, req);
   endtask

   task automatic wipe();
      step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, 1'b1, 1'b0, "R9");
   endtask

   task automatic t_basic_window();
      enter(2, 2, 2, 1'b0, "R1");     // empty after reset
      enter(3, 3, 3, 1'b1, "R3");     // diagonal neighbour
      enter(4, 2, 2, 1'b0, "R3");     // two steps on x: no hazard
      enter(2, 2, 2, 1'b1, "R2");     // own cell now occupied
      enter(2, 0, 2, 1'b0, "R3");     // two steps on y
      enter(1, 1, 1, 1'b1, "R3");     // corner of the cube around 2,2,2
      wipe();
   endtask

   task automatic t_wrap();
      enter(0, 0, 0, 1'b0, "R4");
      enter(7, 7, 7, 1'b1, "R4");     // wraps on all three axes
      enter(7, 0, 1, 1'b1, "R4");
      enter(6, 0, 0, 1'b0, "R4");     // 6 to 0 is two steps
      wipe();
   endtask

   task automatic t_stalled_not_kept();
      enter(1, 1, 1, 1'b0, "R5");
      enter(2, 1, 1, 1'b1, "R5");     // refused, must leave no mark
      retire(1, 1, 1, "R5");
      enter(3, 1, 1, 1'b0, "R5");     // would hit 2,1,1 if it had been kept
      wipe();
   endtask

   task automatic t_hold_release();
      enter(5, 5, 5, 1'b0, "R6");
      enter(5, 5, 6, 1'b1, "R6");
      enter(5, 5, 6, 1'b1, "R6");     // still waiting
      retire(5, 5, 5, "R6");
      enter(5, 5, 6, 1'b0, "R6");
      wipe();
   endtask

   task automatic t_retire_first();
      enter(1, 2, 3, 1'b0, "R7");
      step(1'b1, 1, 2, 4, 1'b1, 1, 2, 3, 1'b0, 1'b0, "R7");
      enter(1, 2, 3, 1'b1, "R7");     // 1,2,4 was admitted
      wipe();
   endtask

   task automatic t_no_underflow();
      retire(4, 4, 4, "R8");          // cell is empty
      enter(4, 4, 4, 1'b0, "R8");
      retire(4, 4, 4, "R8");
      enter(4, 4, 5, 1'b0, "R8");     // cell must be free again
      wipe();
   endtask

   task automatic t_clear();
      enter(2, 5, 2, 1'b0, "R9");
      wipe();
      enter(2, 5, 3, 1'b0, "R9");     // map emptied
      wipe();
      step(1'b1, 6, 6, 6, 1'b0, 0, 0, 0, 1'b1, 1'b0, "R9");
      enter(6, 6, 6, 1'b0, "R9");     // enter during clear not kept
      wipe();
   endtask

   task automatic t_idle();
      enter(0, 4, 0, 1'b0, "R10");
      step(1'b0, 0, 4, 1, 1'b0, 0, 0, 0, 1'b0, 1'b0, "R10");
      enter(0, 4, 1, 1'b1, "R10");
      wipe();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_basic_window();
      t_wrap();
      t_stalled_not_kept();
      t_hold_release();
      t_retire_first();
      t_no_underflow();
      t_clear();
      t_idle();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule